// File: doc/BRIEF.md
# Byte-Sequenced 16x16 Multiplier

This block multiplies two 16-bit operands into a 32-bit product over several clock cycles while owning only one 8x8 unsigned multiplier. Each operand splits into a high and a low byte. A fixed schedule runs the byte pairs through the shared multiplier, one per cycle. The low-by-low product goes into the two least significant result bytes. The high-by-high product goes into the two most significant result bytes. The two cross products are then added one at a time, starting at the second result byte, with the carry running up to the top byte.

In two's-complement mode, two correction cycles follow the four product cycles. The first subtracts operand A from the upper 16 bits of the result when B is negative. The second subtracts operand B from the upper 16 bits when A is negative.

A caller pulses a start input, with a mode select, while the block is idle. It then waits for the one-cycle done pulse and reads the product as four bytes. The operands and the mode are captured when start is accepted. The result is held until the next accepted start.

Top module: `seq_mul16`

## Requirements
- R1: In unsigned mode (`signed_i` = 0) the result equals A*B, where both operands are unsigned 16-bit values.
- R2: In signed mode (`signed_i` = 1) the result equals the two's-complement product of A and B, truncated to 32 bits.
- R3: In unsigned mode, `busy_o` is high for exactly 4 cycles after the start is accepted, with one partial product per cycle.
- R4: In signed mode, `busy_o` is high for exactly 6 cycles: four partial products, then the B-sign correction, then the A-sign correction.
- R5: `done_o` is a single-cycle pulse. It rises in the cycle after the last step and is never high at the same time as `busy_o`.
- R6: A start asserted while `busy_o` is high is ignored. It does not restart or lengthen the operation and produces no extra done pulse.
- R7: Operands and mode are latched when start is accepted. Changes on `a_i`, `b_i` or `signed_i` during the operation do not affect the result.
- R8: After done, the result stays stable until the next accepted start, whatever the operand inputs do.
- R9: After reset, `busy_o` = 0, `done_o` = 0 and the result is zero.
- R10: The result is presented as four bytes: `res3_o` holds bits 31:24, `res2_o` bits 23:16, `res1_o` bits 15:8 and `res0_o` bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted only when idle |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| a_i | input | 16 | Operand A |
| b_i | input | 16 | Operand B |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| res3_o | output | 8 | Result bits 31:24 |
| res2_o | output | 8 | Result bits 23:16 |
| res1_o | output | 8 | Result bits 15:8 |
| res0_o | output | 8 | Result bits 7:0 |

## Verification
The bench builds the block with its default byte width of 8, which gives 16-bit operands and a 32-bit product. With that width, the cases where carries reach the top byte can be driven directly: 0xFFFF*0xFFFF, 0x8000*0x8000 and the signed mixes of most-negative and all-ones operands. Those cases also exercise both sign corrections, on their own and together.

Randomized operands in both modes cover the carry from the cross products into the second and top bytes. On some operations the bench changes the operands, flips the mode and pulses start during the busy window, to show that the latched operands and the fixed 4-cycle or 6-cycle length hold.

// File: rtl/mulseq_pkg.sv
package mulseq_pkg;
  typedef enum logic [2:0] {
    ST_LL = 3'd0,
    ST_HH = 3'd1,
    ST_LH = 3'd2,
    ST_HL = 3'd3,
    ST_CB = 3'd4,
    ST_CA = 3'd5
  } step_e;
endpackage

// File: rtl/mulseq_byte_mult.sv
module mulseq_byte_mult #(
  parameter int W = 8
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] p_o
);
  assign p_o = a_i * b_i;
endmodule

// File: rtl/mulseq_ctrl.sv
module mulseq_ctrl
  import mulseq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  logic  signed_i,
  output logic  accept_o,
  output logic  busy_o,
  output logic  done_o,
  output logic  sgn_o,
  output step_e step_o
);
  logic  busy_q, done_q, sgn_q;
  step_e step_q;
  logic  last;

  assign accept_o = start_i & ~busy_q;
  assign last     = sgn_q ? (step_q == ST_CA) : (step_q == ST_HL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sgn_q  <= 1'b0;
      step_q <= ST_LL;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      sgn_q  <= signed_i;
      step_q <= ST_LL;
    end else if (busy_q) begin
      if (last) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        step_q <= step_e'(step_q + 3'd1);
        done_q <= 1'b0;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign sgn_o  = sgn_q;
  assign step_o = step_q;

  a_r5_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  a_r5_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_q && busy_q));
  a_r6_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && !last) |=> (busy_q && $stable(sgn_q)));
  a_r3_unsigned_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !sgn_q) |-> (step_q <= ST_HL));
endmodule

// File: rtl/mulseq_acc.sv
module mulseq_acc
  import mulseq_pkg::*;
#(
  parameter int W = 8,
  localparam int OW = 2 * W,
  localparam int RW = 4 * W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          busy_i,
  input  logic          sgn_i,
  input  step_e         step_i,
  input  logic [OW-1:0] a_i,
  input  logic [OW-1:0] b_i,
  input  logic [OW-1:0] prod_i,
  output logic [RW-1:0] res_o
);
  logic [RW-1:0]   res_q;
  logic [RW-W-1:0] cross_sum;
  logic [OW-1:0]   hi_cur, hi_sub_a, hi_sub_b;

  assign hi_cur    = res_q[RW-1:OW];
  // Cross product lands at byte 1; carry ripples to the top byte.
  assign cross_sum = res_q[RW-1:W] + {{W{1'b0}}, prod_i};
  assign hi_sub_a  = hi_cur - a_i;
  assign hi_sub_b  = hi_cur - b_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
    end else if (busy_i) begin
      unique case (step_i)
        ST_LL: res_q[OW-1:0]  <= prod_i;
        ST_HH: res_q[RW-1:OW] <= prod_i;
        ST_LH,
        ST_HL: res_q[RW-1:W]  <= cross_sum;
        ST_CB: if (sgn_i && b_i[OW-1]) res_q[RW-1:OW] <= hi_sub_a;
        ST_CA: if (sgn_i && a_i[OW-1]) res_q[RW-1:OW] <= hi_sub_b;
        default: ;
      endcase
    end
  end

  assign res_o = res_q;

  a_r8_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> $stable(res_q));
  a_r2_corr_upper_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && (step_i == ST_CB || step_i == ST_CA)) |=> $stable(res_q[OW-1:0]));
  a_r1_no_corr_unsigned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !sgn_i && step_i == ST_HL) |=> !busy_i);
endmodule

// File: rtl/seq_mul16.sv
module seq_mul16
  import mulseq_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int OW = 2 * BYTE_W,
  localparam int RW = 4 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              signed_i,
  input  logic [OW-1:0]     a_i,
  input  logic [OW-1:0]     b_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [BYTE_W-1:0] res3_o,
  output logic [BYTE_W-1:0] res2_o,
  output logic [BYTE_W-1:0] res1_o,
  output logic [BYTE_W-1:0] res0_o
);
  logic              accept, sgn;
  step_e             step;
  logic [OW-1:0]     a_q, b_q, prod;
  logic [BYTE_W-1:0] m_a, m_b;
  logic [RW-1:0]     res;

  mulseq_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .signed_i (signed_i),
    .accept_o (accept),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .sgn_o    (sgn),
    .step_o   (step)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else if (accept) begin
      a_q <= a_i;
      b_q <= b_i;
    end
  end

  // A low byte on LL/LH, B low byte on LL/HL.
  assign m_a = (step == ST_LL || step == ST_LH) ? a_q[BYTE_W-1:0] : a_q[OW-1:BYTE_W];
  assign m_b = (step == ST_LL || step == ST_HL) ? b_q[BYTE_W-1:0] : b_q[OW-1:BYTE_W];

  mulseq_byte_mult #(.W(BYTE_W)) u_mult (
    .a_i (m_a),
    .b_i (m_b),
    .p_o (prod)
  );

  mulseq_acc #(.W(BYTE_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .busy_i (busy_o),
    .sgn_i  (sgn),
    .step_i (step),
    .a_i    (a_q),
    .b_i    (b_q),
    .prod_i (prod),
    .res_o  (res)
  );

  assign res3_o = res[4*BYTE_W-1:3*BYTE_W];
  assign res2_o = res[3*BYTE_W-1:2*BYTE_W];
  assign res1_o = res[2*BYTE_W-1:BYTE_W];
  assign res0_o = res[BYTE_W-1:0];

  a_r7_ops_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(a_q) && $stable(b_q)));
  a_r5_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o));
endmodule

// File: tb/tb_seq_mul16.sv
module tb_seq_mul16;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        signed_i = 1'b0;
  logic [15:0] a_i = '0;
  logic [15:0] b_i = '0;
  logic        busy_o, done_o;
  logic [7:0]  res3_o, res2_o, res1_o, res0_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_q[$];
  logic [31:0] mon_last;

  always #2 clk_i = ~clk_i;

  seq_mul16 dut (.*);

  function automatic logic [31:0] res_word();
    return {res3_o, res2_o, res1_o, res0_o};
  endfunction

  function automatic logic [31:0] ref_prod(input logic [15:0] a, input logic [15:0] b, input bit sg);
    logic signed [31:0] sa, sb;
    if (!sg) return 32'(a) * 32'(b);
    sa = {{16{a[15]}}, a};
    sb = {{16{b[15]}}, b};
    return 32'(sa * sb);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: pops an expected value on every done pulse (R1/R2/R10, R5, R6).
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && done_o) begin
        chk(!busy_o, "R5 busy with done", 32'(busy_o), 32'd0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 extra done", res_word(), 32'hx);
        end else begin
          mon_last = exp_q.pop_front();
          chk(res_word() == mon_last, "R1/R2/R10 product", res_word(), mon_last);
        end
        @(negedge clk_i);
        chk(!done_o, "R5 done pulse width", 32'(done_o), 32'd0);
      end
    end
  end

  task automatic run_op(input logic [15:0] a, input logic [15:0] b, input bit sg, input bit disturb);
    int n;
    logic [31:0] e;
    e = ref_prod(a, b, sg);
    exp_q.push_back(e);
    a_i = a; b_i = b; signed_i = sg; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    n = 0;
    while (busy_o && n < 20) begin
      n++;
      if (disturb && n == 2) begin
        a_i = ~a; b_i = a ^ b ^ 16'h5a5a; signed_i = ~sg; start_i = 1'b1;  // R6, R7
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk_i);
    end
    start_i = 1'b0;
    chk(n == (sg ? 6 : 4), sg ? "R4 signed length" : "R3 unsigned length", 32'(n), sg ? 32'd6 : 32'd4);
    chk(done_o, "R5 done after last step", 32'(done_o), 32'd1);
    if (disturb) begin
      for (int k = 0; k < 3; k++) begin
        a_i = a_i + 16'h1357; b_i = ~b_i; signed_i = ~signed_i;
        @(negedge clk_i);
      end
      chk(res_word() == e, "R8 hold after done", res_word(), e);
    end
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk({busy_o, done_o} == 2'b00, "R9 reset flags", 32'({busy_o, done_o}), 32'd0);
    chk(res_word() == 32'd0, "R9 reset result", res_word(), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // Corners: R1 unsigned, R2 signed (both correction paths).
    run_op(16'h0000, 16'h1234, 1'b0, 1'b0);
    run_op(16'hABCD, 16'h0000, 1'b1, 1'b0);
    run_op(16'hFFFF, 16'hFFFF, 1'b0, 1'b0);
    run_op(16'hFFFF, 16'hFFFF, 1'b1, 1'b0);
    run_op(16'h8000, 16'h8000, 1'b0, 1'b0);
    run_op(16'h8000, 16'h8000, 1'b1, 1'b0);
    run_op(16'h8000, 16'hFFFF, 1'b1, 1'b0);
    run_op(16'h7FFF, 16'h8000, 1'b1, 1'b0);
    run_op(16'h0001, 16'hFFFF, 1'b1, 1'b0);
    run_op(16'h00FF, 16'hFF00, 1'b0, 1'b1);
    run_op(16'h1234, 16'h5678, 1'b1, 1'b1);
    run_op(16'hF00D, 16'hBEEF, 1'b1, 1'b1);
    for (int i = 0; i < 60; i++) begin
      run_op(16'($urandom), 16'($urandom), 1'($urandom), (i % 5) == 0);
    end
    repeat (3) @(negedge clk_i);
    chk(exp_q.size() == 0, "R6 done count", 32'(exp_q.size()), 32'd0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule